// File: doc/BRIEF.md
# ADC Serial Port Transaction Engine

This block is a four-wire serial master for a delta-sigma converter. It drives an active-low chip select, a serial clock and a data output line, and it samples the converter's data line. A host starts one transaction at a time through a request port. The port carries an operation code, a command byte and a 24-bit write word. The block raises `done` for one cycle when the transaction has finished. Reads return their 24-bit word on `rd_data`.

There are four operations. A port resynchronisation sequence puts the converter's serial port back into its command state. A register write sends a command byte followed by three data bytes. A register read sends a command byte and then clocks in three bytes. A calibration sends a fixed command and then waits, with chip select still low, until the converter pulls its data line low. A timeout limits that wait. A parameterised divider sets the serial clock. With `SCLK_HALF` system cycles per half period, a 50 MHz system clock and the default of 13 give about 1.92 MHz, which is inside a 2 MHz converter limit.

Back-pressure at the request port: `req_ready` is high only while the engine is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A `req_valid` that is held while `req_ready` is low is neither queued nor remembered.

Top module: `adc_sport_engine`

## Requirements
- R1: `req_ready` is high only while idle, and a request is taken only on an edge with `req_valid` and `req_ready` both high. From the cycle after acceptance up to and including the one-cycle `done` pulse, `busy` is high and `req_ready` is low. In the cycle after `done`, `busy` is low again. Requests made while busy start nothing.
- R2: Operation code 0 (resync) holds chip select low for one window of 128 serial clocks. In that window it sends fifteen bytes of 0xFF and then one byte of 0xFE.
- R3: Every transmitted byte goes out most significant bit first. Each bit is placed on `spi_mosi` during the clock-low phase and held through the following high phase.
- R4: Operation code 1 (write) holds chip select low for 32 serial clocks. It sends `req_cmd`, then `req_wdata[23:16]`, then `[15:8]`, then `[7:0]`.
- R5: Operation code 2 (read) sends `req_cmd` and then clocks in 24 bits on `spi_miso`. The first bit received becomes `rd_data[23]`. `rd_data` holds the new word from the `done` pulse until the next read completes.
- R6: `spi_mosi` is 0 whenever no byte is being transmitted. This covers the 24 receive clocks of a read and all idle time.
- R7: Operation code 3 (calibrate) sends the byte `CAL_CMD` (default 0x81). It then keeps chip select low until `spi_miso` is sampled low, and only then releases chip select and pulses `done` with `timeout_err` at 0.
- R8: In the calibration wait, if `spi_miso` stays high for `CAL_TIMEOUT` consecutive cycles, the engine releases chip select, pulses `done` and sets `timeout_err`. The flag holds until the next request is accepted.
- R9: `spi_sclk` idles low and is high only while chip select is low. Each high phase lasts exactly `SCLK_HALF` system cycles. Each low phase inside a transaction lasts at least `SCLK_HALF` cycles.
- R10: Each received bit is sampled in the last system cycle of the clock-low phase, just before the rising serial clock edge.
- R11: After reset the outputs are: `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, `busy`=0, `done`=0, `timeout_err`=0, `rd_data`=0, and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 2 | 0 resync, 1 write, 2 read, 3 calibrate |
| req_cmd | input | 8 | Command byte for write and read |
| req_wdata | input | 24 | Data word for write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Calibration wait timed out |
| rd_data | output | 24 | Word returned by the last read |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The bench builds the engine with `SCLK_HALF`=2 and `CAL_TIMEOUT`=100. Each serial bit then lasts four system cycles. This keeps the run short enough to sweep writes across sixteen command/data patterns and a walking one through all 24 data bits. Reads are swept the same way against a responding converter model. The short timeout brings both calibration endings into reach, the data line falling in time and the timeout, and it allows the timed-out wait length to be measured.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

  typedef enum logic [1:0] {
    OP_RESYNC = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_CAL    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_SHIFT,
    ST_CALWAIT,
    ST_FINISH
  } ctrl_state_e;

  localparam int BYTE_W        = 8;
  localparam int WORD_W        = 24;
  localparam int RESYNC_BYTES  = 16;
  localparam int REG_BYTES     = 1 + WORD_W / BYTE_W;
  localparam int IDX_W         = $clog2(RESYNC_BYTES);
  localparam logic [BYTE_W-1:0] RESYNC_FILL = 8'hFF;
  localparam logic [BYTE_W-1:0] RESYNC_TAIL = 8'hFE;

endpackage

// File: rtl/adcsp_tick_gen.sv
module adcsp_tick_gen #(
  parameter int HALF = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

endmodule

// File: rtl/adcsp_byte_shifter.sv
module adcsp_byte_shifter #(
  parameter int HALF = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       tx_drive,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int HW = $clog2(HALF + 2);

  logic       tick;
  logic       high_ph;
  logic [2:0] bit_idx;
  logic [7:0] tx_q;
  logic       drive_q;

  adcsp_tick_gen #(.HALF(HALF)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      high_ph   <= 1'b0;
      bit_idx   <= '0;
      tx_q      <= '0;
      drive_q   <= 1'b0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        high_ph <= 1'b0;
        bit_idx <= 3'd7;
        tx_q    <= tx_byte;
        drive_q <= tx_drive;
        sclk    <= 1'b0;
        mosi    <= tx_drive & tx_byte[7];
      end else if (tick) begin
        if (!high_ph) begin
          rx_byte <= {rx_byte[6:0], miso};
          sclk    <= 1'b1;
          high_ph <= 1'b1;
        end else begin
          sclk    <= 1'b0;
          high_ph <= 1'b0;
          if (bit_idx == 3'd0) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
            mosi      <= 1'b0;
          end else begin
            bit_idx <= bit_idx - 1'b1;
            mosi    <= drive_q & tx_q[bit_idx - 1'b1];
          end
        end
      end
    end
  end

  // width watch for the serial clock high phase
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (sclk) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_cnt == HW'(HALF)); // R9

  AST_SCLK_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> hi_cnt < HW'(HALF)); // R9

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R3

endmodule

// File: rtl/adcsp_ctrl.sv
module adcsp_ctrl
  import adcsp_pkg::*;
#(
  parameter logic [7:0] CAL_CMD     = 8'h81,
  parameter int         CAL_TIMEOUT = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_cmd,
  input  logic [23:0] req_wdata,
  output logic        req_ready,
  output logic        busy,
  output logic        done,
  output logic        timeout_err,
  output logic [23:0] rd_data,
  output logic        cs_n,
  input  logic        miso,
  output logic        sh_start,
  output logic [7:0]  sh_byte,
  output logic        sh_drive,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx
);
  localparam int TW = $clog2(CAL_TIMEOUT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(CAL_TIMEOUT - 1);

  ctrl_state_e      state;
  op_e              op_q;
  logic [7:0]       cmd_q;
  logic [23:0]      wdata_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [15:0]      rd_acc;
  logic [TW-1:0]    tmo;

  always_comb begin
    sh_drive = 1'b1;
    sh_byte  = cmd_q;
    last_idx = IDX_W'(REG_BYTES - 1);
    unique case (op_q)
      OP_RESYNC: begin
        sh_byte  = (idx == IDX_W'(RESYNC_BYTES - 1)) ? RESYNC_TAIL : RESYNC_FILL;
        last_idx = IDX_W'(RESYNC_BYTES - 1);
      end
      OP_WRITE: begin
        unique case (idx[1:0])
          2'd1:    sh_byte = wdata_q[23:16];
          2'd2:    sh_byte = wdata_q[15:8];
          2'd3:    sh_byte = wdata_q[7:0];
          default: sh_byte = cmd_q;
        endcase
      end
      OP_READ: begin
        sh_drive = (idx == '0);
      end
      default: begin
        sh_byte  = CAL_CMD;
        last_idx = '0;
      end
    endcase
  end

  assign sh_start  = (state == ST_LAUNCH);
  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      op_q        <= OP_RESYNC;
      cmd_q       <= '0;
      wdata_q     <= '0;
      idx         <= '0;
      rd_acc      <= '0;
      rd_data     <= '0;
      tmo         <= '0;
      cs_n        <= 1'b1;
      timeout_err <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_q        <= op_e'(req_op);
            cmd_q       <= req_cmd;
            wdata_q     <= req_wdata;
            idx         <= '0;
            cs_n        <= 1'b0;
            timeout_err <= 1'b0;
            state       <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (sh_done) begin
            if (op_q == OP_READ && idx != '0) rd_acc <= {rd_acc[7:0], sh_rx};
            if (idx == last_idx) begin
              if (op_q == OP_CAL) begin
                tmo   <= '0;
                state <= ST_CALWAIT;
              end else begin
                if (op_q == OP_READ) rd_data <= {rd_acc, sh_rx};
                cs_n  <= 1'b1;
                state <= ST_FINISH;
              end
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_LAUNCH;
            end
          end
        end
        ST_CALWAIT: begin
          if (!miso) begin
            cs_n  <= 1'b1;
            state <= ST_FINISH;
          end else if (tmo == T_LAST) begin
            cs_n        <= 1'b1;
            timeout_err <= 1'b1;
            state       <= ST_FINISH;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R1

  AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R1

  AST_CS_HELD_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !cs_n); // R7

  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n); // R7

  AST_ERR_ONLY_FROM_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (op_q == OP_CAL && done)); // R8

endmodule

// File: rtl/adc_sport_engine.sv
module adc_sport_engine
  import adcsp_pkg::*;
#(
  parameter int         SCLK_HALF   = 13,
  parameter logic [7:0] CAL_CMD     = 8'h81,
  parameter int         CAL_TIMEOUT = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_cmd,
  input  logic [23:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        timeout_err,
  output logic [23:0] rd_data,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic       sh_start;
  logic [7:0] sh_byte;
  logic       sh_drive;
  logic       sh_done;
  logic       sh_active;
  logic [7:0] sh_rx;

  adcsp_ctrl #(
    .CAL_CMD    (CAL_CMD),
    .CAL_TIMEOUT(CAL_TIMEOUT)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_cmd    (req_cmd),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .timeout_err(timeout_err),
    .rd_data    (rd_data),
    .cs_n       (spi_cs_n),
    .miso       (spi_miso),
    .sh_start   (sh_start),
    .sh_byte    (sh_byte),
    .sh_drive   (sh_drive),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx)
  );

  adcsp_byte_shifter #(.HALF(SCLK_HALF)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sh_start),
    .tx_byte  (sh_byte),
    .tx_drive (sh_drive),
    .miso     (spi_miso),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .active   (sh_active),
    .byte_done(sh_done),
    .rx_byte  (sh_rx)
  );

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n); // R9

  AST_MOSI_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_mosi); // R6

  AST_SHIFT_ONLY_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> (busy && !done)); // R1

endmodule

// File: tb/adc_sport_engine_tb_top.sv
`timescale 1ns/1ps
module adc_sport_engine_tb_top;
  localparam int HALF = 2;
  localparam int TMO  = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_cmd = 8'd0;
  logic [23:0] req_wdata = 24'd0;
  logic        busy, done, timeout_err;
  logic [23:0] rd_data;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b1;

  int checks = 0;
  int fails  = 0;

  int unsigned cyc = 0;
  int          mon_cnt = 0;
  logic [127:0] mon_shift = '0;
  int          cs_falls = 0;
  int unsigned t_rise = 0, t_fall = 0, t_last_fall = 0;
  int          hi_bad = 0, lo_bad = 0;
  bit          resp_read = 1'b0;
  logic [23:0] rdpat = '0;

  always #10 clk = ~clk;

  adc_sport_engine #(
    .SCLK_HALF  (HALF),
    .CAL_CMD    (8'h81),
    .CAL_TIMEOUT(TMO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cmd(req_cmd), .req_wdata(req_wdata),
    .busy(busy), .done(done), .timeout_err(timeout_err), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(negedge spi_cs_n);
    cs_falls++;
    t_fall = cyc;
    if (!resp_read) spi_miso = 1'b1;
  end

  initial forever begin
    @(posedge spi_sclk);
    t_rise = cyc;
    if (cyc - t_fall < HALF) lo_bad++;
    if (!spi_cs_n) begin
      mon_shift = {mon_shift[126:0], spi_mosi};
      mon_cnt++;
    end
  end

  initial forever begin
    @(negedge spi_sclk);
    t_fall = cyc;
    t_last_fall = cyc;
    if (cyc - t_rise != HALF) hi_bad++;
    if (resp_read && mon_cnt >= 8 && mon_cnt < 32) spi_miso = rdpat[31 - mon_cnt];
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] cmd,
                       input logic [23:0] wd);
    @(negedge clk);
    mon_cnt   = 0;
    mon_shift = '0;
    req_op    = op;
    req_cmd   = cmd;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R1 busy after accept", {busy, req_ready}, 2'b10);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R1 done watchdog", done, 1);
    chk(busy && spi_cs_n, "R1 busy and cs released at done", {busy, spi_cs_n}, 2'b11);
    @(negedge clk);
    chk(!busy && req_ready && !done, "R1 idle after done",
        {busy, req_ready, done}, 3'b010);
    chk(!spi_mosi, "R6 mosi low after txn", spi_mosi, 0);
  endtask

  initial begin
    int n;
    int falls0;
    logic [23:0] d;
    logic [7:0]  c;
    #(20 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int falls0;
    logic [23:0] d;
    logic [7:0]  c;
    repeat (3) @(negedge clk);
    // R11 reset values
    chk(spi_cs_n && !spi_sclk && !spi_mosi && !busy && !done && !timeout_err
        && rd_data == 0 && req_ready, "R11 reset state",
        {spi_cs_n, spi_sclk, spi_mosi, busy, done, timeout_err, req_ready}, 7'b1000001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 resync
    falls0 = cs_falls;
    issue(2'd0, 8'h00, 24'h0);
    wait_done(n);
    chk(mon_cnt == 128, "R2 resync clock count", mon_cnt, 128);
    chk(mon_shift == {{120{1'b1}}, 8'hFE}, "R2 resync pattern", mon_shift,
        {{120{1'b1}}, 8'hFE});
    chk(cs_falls - falls0 == 1, "R2 single cs window", cs_falls - falls0, 1);

    // R4 / R3 write sweep
    for (int i = 0; i < 16; i++) begin
      c = 8'(i * 17 + 1);
      d = 24'((i * 32'h0B1C2D) ^ 32'h5A0F3);
      issue(2'd1, c, d);
      wait_done(n);
      chk(mon_cnt == 32, "R4 write clock count", mon_cnt, 32);
      chk(mon_shift[31:0] == {c, d}, "R4 write frame", mon_shift[31:0], {c, d});
    end
    for (int b = 0; b < 24; b++) begin
      d = 24'(1) << b;
      issue(2'd1, 8'h80 >> (b % 8), d);
      wait_done(n);
      chk(mon_shift[31:0] == {8'h80 >> (b % 8), d}, "R3 walking one msb first",
          mon_shift[31:0], {8'h80 >> (b % 8), d});
    end

    // R5 / R10 / R6 reads
    resp_read = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rdpat = 24'(~(i * 32'h111111)) ^ 24'h00C3A5;
      c = 8'h08 + 8'(i);
      issue(2'd2, c, 24'hFFFFFF);
      wait_done(n);
      chk(mon_cnt == 32, "R5 read clock count", mon_cnt, 32);
      chk(rd_data == rdpat, "R5 R10 read data", rd_data, rdpat);
      chk(mon_shift[31:24] == c, "R5 read command", mon_shift[31:24], c);
      chk(mon_shift[23:0] == 0, "R6 mosi low while receiving", mon_shift[23:0], 0);
    end
    for (int b = 0; b < 24; b++) begin
      rdpat = 24'(1) << b;
      issue(2'd2, 8'h0A, 24'h0);
      wait_done(n);
      chk(rd_data == rdpat, "R5 read walking one", rd_data, rdpat);
    end
    resp_read = 1'b0;
    spi_miso = 1'b1;

    // R1 requests while busy are ignored
    falls0 = cs_falls;
    issue(2'd1, 8'h3C, 24'h123456);
    req_op = 2'd2; req_cmd = 8'h55; req_valid = 1'b1;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    wait_done(n);
    repeat (20) @(negedge clk);
    chk(cs_falls - falls0 == 1 && spi_cs_n, "R1 busy request ignored",
        cs_falls - falls0, 1);
    chk(mon_shift[31:0] == {8'h3C, 24'h123456} && mon_cnt == 32,
        "R1 frame unaffected", mon_shift[31:0], {8'h3C, 24'h123456});

    // R9 clock phase widths across everything so far
    chk(hi_bad == 0, "R9 high phase width", hi_bad, 0);
    chk(lo_bad == 0, "R9 low phase width", lo_bad, 0);

    // R7 calibration completes when miso falls
    spi_miso = 1'b1;
    issue(2'd3, 8'h00, 24'h0);
    while (mon_cnt < 8) @(negedge clk);
    repeat (HALF + 40) @(negedge clk);
    chk(!spi_cs_n && !done && busy, "R7 cs held while miso high",
        {spi_cs_n, done, busy}, 3'b001);
    spi_miso = 1'b0;
    wait_done(n);
    chk(mon_shift[7:0] == 8'h81 && mon_cnt == 8, "R7 calibration command",
        mon_shift[7:0], 8'h81);
    chk(!timeout_err, "R7 no error on completion", timeout_err, 0);

    // R8 timeout
    spi_miso = 1'b1;
    issue(2'd3, 8'h00, 24'h0);
    while (mon_cnt < 8 || spi_sclk) @(negedge clk);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n >= TMO && n <= TMO + 3, "R8 timeout length", n, TMO);
    chk(done && timeout_err && spi_cs_n, "R8 timeout outcome",
        {done, timeout_err, spi_cs_n}, 3'b111);
    repeat (10) @(negedge clk);
    chk(timeout_err, "R8 error held", timeout_err, 1);
    issue(2'd1, 8'h01, 24'h0);
    chk(!timeout_err, "R8 error cleared by next request", timeout_err, 0);
    wait_done(n);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule